// File: doc/BRIEF.md
# Keypad Wake-Up Interrupt Controller

This block watches a small input port, normally the row or column lines of a keypad, and raises one shared interrupt whenever any pin that software has selected is pulled low. Each pin is selected by its own bit in a select register. When a selected pin goes low, a sticky event flag is set. This flag drives an interrupt request, gated by an interrupt-enable input. A separate wake request is formed from the raw pins without passing through any flop, so it can bring the processor out of idle or power-down while the core clock is stopped.

The event flag does not record which key was pressed. After the interrupt, software polls the port itself to find the key. The event flag stays set until software clears it. Software clears it by writing 0 to the flag register. If a selected pin is still low at that moment, the flag is set again on the same edge, because set has priority over clear. The block does not scan a key matrix and does not debounce the keys.

Top module: `kpw_top`

## Requirements
- R1: The select register is at address 0 and resets to 00h. Writing it stores all PORT_W bits, and reading address 0 returns the stored value.
- R2: Suppose a selected pin (select bit 1) is low. The event flag (bit 0 of address 1) then reads 1 after the third rising edge that follows the pin change, and not after the second.
- R3: Detection is level-based. While a selected pin stays low, writing 0 to the flag register leaves the flag at 1, because set wins over clear.
- R4: The event flag is sticky. It stays 1 after all selected pins return high. Writing a value with bit 0 = 0 to address 1 clears it. Writing bit 0 = 1 has no effect.
- R5: irq_o is 1 exactly when the event flag is 1 and irq_en_i is 1.
- R6: wake_o is the combinational OR, over all pins, of (select bit AND pin low). It follows the raw pins with no clock, and it is 0 when no selected pin is low.
- R7: After reset, the select register is 00h, the flag is 0, and irq_o and wake_o are 0, even with pins held low.
- R8: A pin whose select bit is 0 has no effect on the flag, irq_o or wake_o.
- R9: Reading address 2 or address 3 returns 0. Writing to either address changes neither the select register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | PORT_W | Raw keypad port pins; a low pin is an active key |
| reg_addr | input | 2 | Register address: 0 = select, 1 = flag |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | PORT_W | Write data |
| reg_rdata | output | PORT_W | Read data for reg_addr, combinational |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Clock-free wake request |

## Verification
Every one of the 256 select values is combined with each single-low pin pattern, with all pins high, and with all pins low. This separates a correct per-bit mask from a shifted mask, an inverted mask, or an unmasked OR, both on wake_o and on the synchronized flag. For each combination, the bench follows the pin back to high to show that the flag is sticky while wake_o drops. It also alternates irq_en_i between combinations to show the interrupt gating. Directed cases cover the following:
- the synchronizer latency, by the cycle in which the flag appears;
- clearing the flag while a pin is still low;
- writing 1 to the flag;
- accesses to the unused addresses;
- the reset state with pins already low.

// File: rtl/kpw_pkg.sv
package kpw_pkg;

   localparam int unsigned KPW_ADDR_W = 2;

   typedef enum logic [KPW_ADDR_W-1:0] {
      KPW_REG_SEL  = 2'd0,
      KPW_REG_FLAG = 2'd1,
      KPW_REG_RSV2 = 2'd2,
      KPW_REG_RSV3 = 2'd3
   } kpw_reg_e;

   localparam int unsigned KPW_FLAG_BIT = 0;

endpackage

// File: rtl/kpw_sync.sv
module kpw_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam logic [WIDTH-1:0] IDLE = {WIDTH{1'b1}};

   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("kpw_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= IDLE;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= IDLE;
         else        stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/kpw_detect.sv
module kpw_detect #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] pins_raw,
   input  logic [WIDTH-1:0] pins_sync,
   input  logic [WIDTH-1:0] sel,
   output logic             hit_sync,
   output logic             wake
);

   logic [WIDTH-1:0] act_sync;
   logic [WIDTH-1:0] act_raw;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign act_sync[i] = sel[i] & ~pins_sync[i];
      assign act_raw[i]  = sel[i] & ~pins_raw[i];
   end

   assign hit_sync = |act_sync;
   assign wake     = |act_raw;

endmodule

// File: rtl/kpw_regs.sv
module kpw_regs
   import kpw_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [KPW_ADDR_W-1:0] addr,
   input  logic                  wr,
   input  logic [WIDTH-1:0]      wdata,
   input  logic                  hit,
   output logic [WIDTH-1:0]      sel_q,
   output logic                  flag_q,
   output logic [WIDTH-1:0]      rdata
);

   logic wr_sel;
   logic clr_flag;

   assign wr_sel   = wr && (addr == KPW_REG_SEL);
   assign clr_flag = wr && (addr == KPW_REG_FLAG) && !wdata[KPW_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= wdata;
   end

   // set has priority over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         KPW_REG_SEL:  rdata = sel_q;
         KPW_REG_FLAG: rdata[KPW_FLAG_BIT] = flag_q;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/kpw_top.sv
module kpw_top
   import kpw_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORT_W-1:0]     pins_i,
   input  logic [KPW_ADDR_W-1:0] reg_addr,
   input  logic                  reg_wr,
   input  logic [PORT_W-1:0]     reg_wdata,
   output logic [PORT_W-1:0]     reg_rdata,
   input  logic                  irq_en_i,
   output logic                  irq_o,
   output logic                  wake_o
);

   initial begin
      assert (PORT_W >= 1 && PORT_W <= 32) else $error("kpw_top: PORT_W out of range");
   end

   logic [PORT_W-1:0] pins_sync;
   logic [PORT_W-1:0] sel_q;
   logic              hit_sync;
   logic              flag_q;

   kpw_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins_i),
      .dout (pins_sync)
   );

   kpw_detect #(.WIDTH(PORT_W)) u_det (
      .pins_raw (pins_i),
      .pins_sync(pins_sync),
      .sel      (sel_q),
      .hit_sync (hit_sync),
      .wake     (wake_o)
   );

   kpw_regs #(.WIDTH(PORT_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (reg_addr),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .hit   (hit_sync),
      .sel_q (sel_q),
      .flag_q(flag_q),
      .rdata (reg_rdata)
   );

   assign irq_o = flag_q & irq_en_i;

endmodule

// File: rtl/kpw_checker.sv
module kpw_checker #(
   parameter int unsigned PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] pins_i,
   input logic [1:0]        reg_addr,
   input logic              reg_wr,
   input logic [PORT_W-1:0] reg_wdata,
   input logic              irq_en_i,
   input logic              irq_o,
   input logic              wake_o,
   input logic              hit,
   input logic              flag,
   input logic [PORT_W-1:0] sel
);

   logic clr_req;
   assign clr_req = reg_wr && (reg_addr == 2'd1) && !reg_wdata[0];

   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(hit));

   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);

   p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && clr_req && !hit) |=> !flag);

   p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en_i);

   p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag);

   p_wake_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&pins_i) |-> !wake_o);

   p_wake_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !wake_o);

endmodule

bind kpw_top kpw_checker #(.PORT_W(PORT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pins_i   (pins_i),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .irq_en_i (irq_en_i),
   .irq_o    (irq_o),
   .wake_o   (wake_o),
   .hit      (hit_sync),
   .flag     (flag_q),
   .sel      (sel_q)
);

// File: tb/tb_kpw_top.sv
`timescale 1ns/1ps
module tb_kpw_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pins_i = '1;
   logic [1:0]   reg_addr = 2'd1;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         irq_en_i = 1'b0;
   logic         irq_o;
   logic         wake_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   kpw_top dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_en_i(irq_en_i), .irq_o(irq_o), .wake_o(wake_o)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd1;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_addr = 2'd1;
      #0.1;
   endtask

   logic [W-1:0] v;

   initial begin
      // R7: reset state with pins low
      pins_i = 8'h00;
      irq_en_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rd_reg(2'd0, v); chk("R7 sel", v, 8'h00);
      rd_reg(2'd1, v); chk("R7 flag", v, 8'h00);
      chk("R7 irq", {7'd0, irq_o}, 8'h00);
      chk("R7 wake", {7'd0, wake_o}, 8'h00);
      pins_i = '1;
      repeat (3) @(negedge clk);

      // R1: select readback
      wr_reg(2'd0, 8'hA5);
      rd_reg(2'd0, v); chk("R1 sel A5", v, 8'hA5);

      // R2: latency, flag after third edge not second
      wr_reg(2'd0, 8'h01);
      pins_i = 8'hFE;
      #0.5 chk("R6 wake raw", {7'd0, wake_o}, 8'h01);
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd_reg(2'd1, v); chk("R2 not after 2 edges", v, 8'h00);
      @(posedge clk); @(negedge clk);
      rd_reg(2'd1, v); chk("R2 after 3 edges", v, 8'h01);

      // R3: clear while still low keeps flag
      wr_reg(2'd1, 8'h00);
      rd_reg(2'd1, v); chk("R3 set beats clear", v, 8'h01);

      // R4: writing 1 no effect, clear after release
      pins_i = '1;
      repeat (4) @(negedge clk);
      wr_reg(2'd1, 8'hFF);
      rd_reg(2'd1, v); chk("R4 write 1 ignored", v, 8'h01);
      wr_reg(2'd1, 8'hFE);
      rd_reg(2'd1, v); chk("R4 clear", v, 8'h00);

      // R9: reserved addresses
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd3, 8'hFF);
      rd_reg(2'd2, v); chk("R9 rd addr2", v, 8'h00);
      rd_reg(2'd3, v); chk("R9 rd addr3", v, 8'h00);
      rd_reg(2'd0, v); chk("R9 sel unchanged", v, 8'h01);
      rd_reg(2'd1, v); chk("R9 flag unchanged", v, 8'h00);

      // Sweep: all select values x patterns (R2 R4 R5 R6 R8)
      for (int m = 0; m < 256; m++) begin
         wr_reg(2'd0, m[W-1:0]);
         for (int k = 0; k < 10; k++) begin
            logic [W-1:0] p;
            logic         e;
            if (k < 8)       p = ~(8'h01 << k);
            else if (k == 8) p = 8'hFF;
            else             p = 8'h00;
            e = |(m[W-1:0] & ~p);
            irq_en_i = k[0];
            pins_i = p;
            #0.5 chk("R6 R8 wake", {7'd0, wake_o}, {7'd0, e});
            repeat (3) @(posedge clk);
            @(negedge clk);
            rd_reg(2'd1, v); chk("R2 R8 flag", v, {7'd0, e});
            chk("R5 irq", {7'd0, irq_o}, {7'd0, e & k[0]});
            pins_i = '1;
            #0.5 chk("R6 wake release", {7'd0, wake_o}, 8'h00);
            repeat (3) @(posedge clk);
            @(negedge clk);
            rd_reg(2'd1, v); chk("R4 sticky", v, {7'd0, e});
            wr_reg(2'd1, 8'h00);
            rd_reg(2'd1, v); chk("R4 cleared", v, 8'h00);
         end
      end

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule